// File: doc/BRIEF.md
# Write-Only I2C Configuration Register Slave

This block is the serial configuration port of a video decoder. It watches the two I2C lines and finds START and STOP conditions. It accepts only write transactions addressed to its own 7-bit slave address. One bit of that address is chosen by a strap pin, so two decoders can share a bus. After the address byte, the first byte is taken as a register subaddress. Every data byte that follows is stored at the current subaddress, and the subaddress then steps up by one. This lets a host load a run of registers in one transaction.

The block acknowledges a byte only when it can accept it. It gives no acknowledge to a foreign address, to a read request, to a subaddress outside the writable range (including the read-only status location at 0x20), or to a data byte whose subaddress has run past the last register. After such a refusal it stays off the bus until the next START. Every register is driven onto a flat parallel output for the decoder core to use, and each register returns to a fixed default on reset.

Top module: `i2c_cfg_slave`

## Requirements
- R1: While `rst` is high, and at the first cycle after it falls, register 0x00 reads 0x40 (bit 0 clear, so pin-controlled mode), register 0x04 reads 0x1E, and every other register reads 0x00. Register n sits at bits [8n+7:8n] of `cfg_regs`.
- R2: The slave acknowledges an address byte whose upper seven bits are 1000001 when `addr_strap` is 0, or 1000011 when it is 1, and whose last bit (R/W) is 0.
- R3: An address byte whose upper seven bits do not match gets no acknowledge, and no register changes.
- R4: An address byte with the R/W bit set to 1 (read) gets no acknowledge, and no register changes.
- R5: A subaddress byte from 0x00 to 0x14 is acknowledged. Any larger value, including 0x20, gets no acknowledge.
- R6: Each acknowledged data byte is written to the current subaddress, and the subaddress then increases by one. Data bytes reach successive registers.
- R7: A data byte that arrives when the subaddress has passed 0x14 gets no acknowledge and writes nothing.
- R8: After any byte without an acknowledge, later bytes get no acknowledge and write nothing until a new START.
- R9: A START in the middle of a transaction, including a repeated START with no STOP before it, restarts address reception at the first bit.
- R10: The acknowledge pulls SDA low from the SCL falling edge after the eighth bit until the SCL falling edge after the ninth bit. SDA is never driven at any other time, and the drive never changes while SCL is high.
- R11: After a STOP, bytes clocked without a new START get no acknowledge and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level, asynchronous |
| sda_in | input | 1 | Bus data line level, asynchronous |
| addr_strap | input | 1 | Selects the variable slave address bit |
| sda_pull_low | output | 1 | High to pull SDA low (open-drain acknowledge) |
| cfg_regs | output | NUM_REGS*8 | All register contents, register n at bits [8n+7:8n] |

## Verification
The bench probes the edges of the register map. A burst that starts at 0x13 must fill the last two registers and then get no acknowledge on the third byte. A design that wrapped or failed to stop would corrupt register 0x00 or some register outside the map. Foreign addresses, read requests, subaddress 0x20 and bytes clocked after a STOP are each followed by more bytes. A design that did not latch its refusal would acknowledge these later bytes or write them. A repeated START after a partial write must restart address reception, or the new address byte would be taken as data. After every acknowledge, SDA must be released once the ninth clock ends. A late release would hold the line low into the next byte.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    localparam int CFG_W        = 8;
    localparam int CFG_NUM_REGS = 21;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_HAND,
        ST_ACK,
        ST_SKIP
    } bus_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_SUB,
        PH_DATA
    } byte_phase_e;

    typedef struct packed {
        logic scl_lvl;
        logic sda_lvl;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    typedef struct packed {
        logic             en;
        logic [7:0]       addr;
        logic [CFG_W-1:0] data;
    } wr_req_t;

    function automatic logic [CFG_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h40;
            4:       return 8'h1E;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/i2c_cfg_linesync.sv
module i2c_cfg_linesync
    import i2c_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic                   scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
            scl_q  <= scl_sh[SYNC_STAGES-1];
            sda_q  <= sda_sh[SYNC_STAGES-1];
        end
    end

    always_comb begin
        ev.scl_lvl  = scl_sh[SYNC_STAGES-1];
        ev.sda_lvl  = sda_sh[SYNC_STAGES-1];
        ev.scl_rise = ev.scl_lvl & ~scl_q;
        ev.scl_fall = ~ev.scl_lvl & scl_q;
        ev.start    = ev.scl_lvl & scl_q & sda_q & ~ev.sda_lvl;
        ev.stop     = ev.scl_lvl & scl_q & ~sda_q & ev.sda_lvl;
    end

endmodule

// File: rtl/i2c_cfg_fsm.sv
module i2c_cfg_fsm
    import i2c_cfg_pkg::*;
#(
    parameter int         NUM_REGS  = CFG_NUM_REGS,
    parameter logic [6:0] BASE_ADDR = 7'b1000001,
    parameter int         STRAP_BIT = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  line_ev_t ev,
    input  logic     addr_strap,
    output logic     sda_pull_low,
    output wr_req_t  wr
);
    localparam logic [7:0] LAST_SUB = 8'(NUM_REGS - 1);

    bus_state_e  state;
    byte_phase_e phase;
    logic [2:0]  bit_cnt;
    logic [7:0]  shreg;
    logic [7:0]  ptr;
    logic        ack_ok;
    logic [7:0]  rx_byte;
    logic [6:0]  my_addr;
    logic        accept;

    assign rx_byte = {shreg[6:0], ev.sda_lvl};
    assign my_addr = BASE_ADDR | (7'(addr_strap) << STRAP_BIT);

    always_comb begin
        case (phase)
            PH_ADDR: accept = (rx_byte[7:1] == my_addr) && !rx_byte[0];
            PH_SUB:  accept = (rx_byte <= LAST_SUB);
            default: accept = (ptr <= LAST_SUB);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            phase   <= PH_ADDR;
            bit_cnt <= '0;
            shreg   <= '0;
            ptr     <= '0;
            ack_ok  <= 1'b0;
            wr      <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.start) begin
                state   <= ST_RX;
                phase   <= PH_ADDR;
                bit_cnt <= '0;
            end else if (ev.stop) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_RX: if (ev.scl_rise) begin
                        shreg   <= rx_byte;
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            ack_ok <= accept;
                            state  <= ST_HAND;
                            if (phase == PH_SUB)
                                ptr <= rx_byte;
                            if (phase == PH_DATA && accept) begin
                                wr  <= '{en: 1'b1, addr: ptr, data: rx_byte};
                                ptr <= ptr + 8'd1;
                            end
                        end
                    end
                    ST_HAND: if (ev.scl_fall)
                        state <= ack_ok ? ST_ACK : ST_SKIP;
                    ST_ACK: if (ev.scl_fall) begin
                        state   <= ST_RX;
                        bit_cnt <= '0;
                        phase   <= (phase == PH_ADDR) ? PH_SUB : PH_DATA;
                    end
                    default: state <= state;
                endcase
            end
        end
    end

    assign sda_pull_low = (state == ST_ACK);

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == ST_RX && bit_cnt == 3'd0 && phase == PH_ADDR));

    // R10
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.scl_lvl && $past(ev.scl_lvl)) |-> $stable(sda_pull_low));

    // R8
    skip_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SKIP && !ev.start && !ev.stop) |=> (state == ST_SKIP));

endmodule

// File: rtl/i2c_cfg_regfile.sv
module i2c_cfg_regfile
    import i2c_cfg_pkg::*;
#(
    parameter int NUM_REGS = CFG_NUM_REGS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  wr_req_t                   wr,
    output logic [NUM_REGS*CFG_W-1:0] regs
);
    localparam logic [7:0] LAST_SUB = 8'(NUM_REGS - 1);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g*CFG_W +: CFG_W] <= reg_default(g);
            else if (wr.en && wr.addr == 8'(g))
                regs[g*CFG_W +: CFG_W] <= wr.data;
        end

        // R1
        reset_dflt_chk: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (regs[g*CFG_W +: CFG_W] == reg_default(g)));
    end

    // R7
    wr_in_map_chk: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (wr.addr <= LAST_SUB));

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
    import i2c_cfg_pkg::*;
#(
    parameter int         NUM_REGS    = CFG_NUM_REGS,
    parameter logic [6:0] BASE_ADDR   = 7'b1000001,
    parameter int         STRAP_BIT   = 1,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      scl_in,
    input  logic                      sda_in,
    input  logic                      addr_strap,
    output logic                      sda_pull_low,
    output logic [NUM_REGS*CFG_W-1:0] cfg_regs
);
    line_ev_t ev;
    wr_req_t  wr;

    i2c_cfg_linesync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    i2c_cfg_fsm #(
        .NUM_REGS  (NUM_REGS),
        .BASE_ADDR (BASE_ADDR),
        .STRAP_BIT (STRAP_BIT)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .ev           (ev),
        .addr_strap   (addr_strap),
        .sda_pull_low (sda_pull_low),
        .wr           (wr)
    );

    i2c_cfg_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .regs (cfg_regs)
    );

endmodule

// File: tb/tb_i2c_cfg_slave.sv
module tb_i2c_cfg_slave;
    localparam int NREG = 21;
    localparam int H    = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic strap = 1'b0;
    logic sda_pull_low;
    logic sda_bus;
    logic [NREG*8-1:0] cfg_regs;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [NREG];

    typedef struct { bit ack; string tag; } exp_t;
    exp_t exp_q[$];
    bit   ack_obs;
    event ack_ev;

    always #2.5 clk = ~clk;
    assign sda_bus = !(m_low || sda_pull_low);

    i2c_cfg_slave dut (
        .clk          (clk),
        .rst          (rst),
        .scl_in       (scl),
        .sda_in       (sda_bus),
        .addr_strap   (strap),
        .sda_pull_low (sda_pull_low),
        .cfg_regs     (cfg_regs)
    );

    task automatic wait_h(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops expected acknowledge and compares with bus observation
    initial forever begin
        exp_t e;
        @(ack_ev);
        e = exp_q.pop_front();
        checks++;
        if (ack_obs != e.ack) begin
            errors++;
            $display("FAIL %s ack actual=%0d expected=%0d", e.tag, ack_obs, e.ack);
        end
    end

    task automatic start_c();
        m_low = 1'b0; wait_h(H);
        scl = 1'b1;   wait_h(H);
        m_low = 1'b1; wait_h(H);
        scl = 1'b0;   wait_h(H);
    endtask

    task automatic stop_c();
        m_low = 1'b1; wait_h(H);
        scl = 1'b1;   wait_h(H);
        m_low = 1'b0; wait_h(H);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
        exp_t e;
        e.ack = exp_ack;
        e.tag = tag;
        exp_q.push_back(e);
        for (int i = 7; i >= 0; i--) begin
            m_low = !b[i]; wait_h(H);
            scl = 1'b1;    wait_h(H);
            scl = 1'b0;
        end
        m_low = 1'b0; wait_h(H);
        scl = 1'b1;   wait_h(H/2);
        ack_obs = !sda_bus;
        -> ack_ev;
        wait_h(H/2);
        scl = 1'b0;   wait_h(H/2);
        checks++;
        if (sda_pull_low !== 1'b0) begin
            errors++;
            $display("FAIL R10 release actual=%0b expected=0", sda_pull_low);
        end
    endtask

    task automatic check_regs(input string tag);
        bit bad = 0;
        checks++;
        for (int r = 0; r < NREG; r++) begin
            if (cfg_regs[r*8 +: 8] !== mdl[r]) begin
                bad = 1;
                $display("FAIL %s reg%0d actual=%h expected=%h", tag, r, cfg_regs[r*8 +: 8], mdl[r]);
            end
        end
        if (bad) errors++;
    endtask

    initial begin
        #(5 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < NREG; r++) mdl[r] = 8'h00;
        mdl[0] = 8'h40;
        mdl[4] = 8'h1E;
        wait_h(10);
        check_regs("R1");
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check_regs("R1");
        wait_h(H);

        // R2 R6: strap low address, burst from 0x00
        start_c();
        send_byte(8'h82, 1, "R2");
        send_byte(8'h00, 1, "R5");
        send_byte(8'h01, 1, "R6");
        send_byte(8'h22, 1, "R6");
        send_byte(8'h33, 1, "R6");
        stop_c();
        mdl[0] = 8'h01; mdl[1] = 8'h22; mdl[2] = 8'h33;
        check_regs("R6");

        // R3 R8: foreign address, later bytes refused
        start_c();
        send_byte(8'h86, 0, "R3");
        send_byte(8'h05, 0, "R8");
        send_byte(8'hAA, 0, "R8");
        stop_c();
        check_regs("R3");

        // R4: read request
        start_c();
        send_byte(8'h83, 0, "R4");
        send_byte(8'h00, 0, "R8");
        stop_c();
        check_regs("R4");

        // R2 R7: strap high, run off the end of the map
        strap = 1'b1;
        wait_h(H);
        start_c();
        send_byte(8'h86, 1, "R2");
        send_byte(8'h13, 1, "R5");
        send_byte(8'hA5, 1, "R6");
        send_byte(8'h5A, 1, "R6");
        send_byte(8'h77, 0, "R7");
        send_byte(8'h99, 0, "R8");
        stop_c();
        mdl[19] = 8'hA5; mdl[20] = 8'h5A;
        check_regs("R7");

        // R5: status location and first missing subaddress
        start_c();
        send_byte(8'h86, 1, "R2");
        send_byte(8'h20, 0, "R5");
        send_byte(8'hEE, 0, "R8");
        stop_c();
        start_c();
        send_byte(8'h86, 1, "R2");
        send_byte(8'h15, 0, "R5");
        stop_c();
        check_regs("R5");

        // R2: strap high no longer answers the low address
        start_c();
        send_byte(8'h82, 0, "R2");
        stop_c();

        // R9: repeated start after a partial write
        start_c();
        send_byte(8'h86, 1, "R9");
        send_byte(8'h05, 1, "R9");
        send_byte(8'h11, 1, "R9");
        start_c();
        send_byte(8'h86, 1, "R9");
        send_byte(8'h07, 1, "R9");
        send_byte(8'h44, 1, "R9");
        stop_c();
        mdl[5] = 8'h11; mdl[7] = 8'h44;
        check_regs("R9");

        // R11: bytes after STOP without START
        send_byte(8'h86, 0, "R11");
        send_byte(8'h03, 0, "R11");
        send_byte(8'hFF, 0, "R11");
        stop_c();
        check_regs("R11");

        wait_h(H);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule